// File: doc/BRIEF.md
# Circuit Setup Initiator with Watchdog

This block is the endpoint controller of a node that opens a circuit through a mesh interconnect. When the local processing element asks for a connection, the controller emits a one-cycle route-packet strobe and then waits for the far end to answer. A grant lets the payload move over the locked circuit; a refuse from a busy target, a CRC error report, or an expired watchdog ends the attempt early. At the end of a good transfer the circuit enable drops so that the path along the way is released.

The node can act as the data sender or as the data receiver of the circuit. As a sender it holds the local producer back (ready low) until the circuit is granted, forwards beats while the circuit is open, and drops enable after the last beat, then waits for the far end's unlink. As a receiver it keeps enable high while data arrives and raises unlink itself when the far end reports the end of data. A multicast attempt always sends and waits for a programmed number of grants before releasing data. A countdown watchdog is loaded with a caller-supplied cycle margin when the request is taken, and an expiry forces immediate unlock and an overtime flag.

Every attempt ends with a one-cycle done pulse and a two-bit status code.

Top module: `cxn_setup_initiator`

## Requirements
- R1: A request seen while idle makes route_o high for exactly one cycle, in the cycle after the request is sampled, and busy_o stays high until the attempt ends; a request while busy is ignored (no second route_o pulse).
- R2: lcl_ready_o is high only while the circuit is open (link_en_o high) in sender mode; before the grant it stays low even when lcl_valid_i is high.
- R3: The circuit opens (link_en_o high) in the cycle after the grant that completes the grant count: 1 for unicast, P for multicast, with P = 0 treated as 1.
- R4: grant_refuse_i while waiting for grants ends the attempt with status 1 (refused); link_en_o never rises.
- R5: The watchdog is loaded with tmo_i when the request is taken; with no answer, ot_o and unlink_o are high together in the (tmo_i+2)-th cycle after the request cycle, and the attempt ends with status 2 (timeout). Expiry wins over a refuse or grant in the same cycle.
- R6: In sender mode, the cycle after a beat with lcl_valid_i and lcl_last_i, link_en_o is low; the attempt ends with status 0 (done) in the cycle after unlink_i is sampled.
- R7: In receiver mode, link_en_o is high while open, lcl_ready_o stays low, and peer_end_i makes unlink_o high for one cycle followed by done with status 0.
- R8: A multicast request always runs in sender mode, whatever req_sender_i says.
- R9: crc_err_i while the circuit is open or closing ends the attempt with status 3 (CRC error), unlink_o high and ot_o low.
- R10: The grant count and the watchdog are cleared on every return to idle, so a new multicast needs its full P grants again.
- R11: done_o is a one-cycle pulse in the cycle the block returns to idle, and status_o holds the code of the last finished attempt until the next one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Open-circuit request from the local element |
| req_sender_i | input | 1 | 1: this node sends the payload; 0: it receives |
| req_mcast_i | input | 1 | Request is a multicast |
| req_grants_i | input | CNT_W | Grants to collect for multicast (P) |
| tmo_i | input | TMR_W | Watchdog margin in cycles |
| route_o | output | 1 | One-cycle strobe: issue route packet |
| grant_i | input | 1 | Transmission grant pulse from a target |
| grant_refuse_i | input | 1 | Transmission refuse from a busy target |
| crc_err_i | input | 1 | CRC error reported by the receiver |
| unlink_i | input | 1 | Far-end unlink (sender mode) |
| peer_end_i | input | 1 | Far end reports end of data (receiver mode) |
| lcl_valid_i | input | 1 | Local producer has a beat |
| lcl_last_i | input | 1 | Beat is the final one |
| lcl_ready_o | output | 1 | Backpressure to the local producer |
| link_en_o | output | 1 | Circuit enable |
| unlink_o | output | 1 | Release of the circuit from this end |
| ot_o | output | 1 | Overtime exception flag |
| busy_o | output | 1 | Attempt in progress |
| done_o | output | 1 | One-cycle end-of-attempt pulse |
| status_o | output | 2 | 0 done, 1 refused, 2 timeout, 3 CRC error |

## Verification
The main path is tried with a unicast sender, a unicast receiver, and multicasts with P of 3, each telling apart whether data is released after the right number of grants and whether the closing handshake runs from the correct end. Abort patterns (refuse, silence until the watchdog fires, CRC error mid-transfer) separate the three failure codes and check that overtime is flagged only for expiry, with the expiry cycle counted exactly. A multicast aborted after two grants followed by a fresh one shows whether the grant count is really cleared, and a stray request while busy shows that no second route strobe leaks out.

// File: rtl/cxn_setup_pkg.sv
package cxn_setup_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_ROUTE  = 3'd1,
    S_WAIT   = 3'd2,
    S_XFER   = 3'd3,
    S_CLOSE  = 3'd4,
    S_FAIL   = 3'd5
  } cxn_state_e;

  typedef enum logic [1:0] {
    ST_DONE    = 2'd0,
    ST_REFUSED = 2'd1,
    ST_TIMEOUT = 2'd2,
    ST_CRC     = 2'd3
  } cxn_status_e;
endpackage

// File: rtl/cxn_watchdog.sv
module cxn_watchdog #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [TMR_W-1:0] value_i,
  output logic             expired_o
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | clr_i | (run_i & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = value_i;
    else if (clr_i)  cnt_d = '0;
    else if (run_i)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = run_i & (cnt_q == '0);
endmodule

// File: rtl/cxn_grant_ctr.sv
module cxn_grant_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clr_i,
  input  logic             mcast_i,
  input  logic [CNT_W-1:0] need_i,
  input  logic             inc_i,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, tgt_q, tgt_d;
  logic [CNT_W:0]   cnt_nxt;
  logic             cnt_en, tgt_en;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  assign hit_o   = inc_i & (cnt_nxt == {1'b0, tgt_q});

  always_comb begin
    tgt_d = ONE;
    if (mcast_i && need_i != '0) tgt_d = need_i;
  end
  assign tgt_en = load_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i || clr_i) cnt_d = '0;
    else if (inc_i)      cnt_d = cnt_nxt[CNT_W-1:0];
  end
  assign cnt_en = load_i | clr_i | inc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tgt_q <= ONE;
    else if (tgt_en) tgt_q <= tgt_d;
  end
endmodule

// File: rtl/cxn_setup_fsm.sv
module cxn_setup_fsm
  import cxn_setup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       req_sender_i,
  input  logic       req_mcast_i,
  input  logic       expire_i,
  input  logic       grant_i,
  input  logic       grant_hit_i,
  input  logic       refuse_i,
  input  logic       crc_err_i,
  input  logic       unlink_i,
  input  logic       peer_end_i,
  input  logic       lcl_valid_i,
  input  logic       lcl_last_i,
  output logic       load_o,
  output logic       clr_o,
  output logic       run_o,
  output logic       inc_o,
  output logic       route_o,
  output logic       link_en_o,
  output logic       lcl_ready_o,
  output logic       unlink_o,
  output logic       ot_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] status_o
);
  cxn_state_e  st_q, st_d;
  cxn_status_e fcode_q, fcode_d, stat_q, stat_d;
  logic        snd_q, snd_d, done_q, done_d;
  logic        fcode_en, stat_en, snd_en;

  always_comb begin
    st_d     = st_q;
    fcode_d  = fcode_q;
    fcode_en = 1'b0;
    stat_d   = stat_q;
    stat_en  = 1'b0;
    done_d   = 1'b0;
    unique case (st_q)
      S_IDLE:  if (req_i) st_d = S_ROUTE;
      S_ROUTE: st_d = S_WAIT;
      S_WAIT: begin
        if (expire_i) begin
          st_d = S_FAIL; fcode_d = ST_TIMEOUT; fcode_en = 1'b1;
        end else if (refuse_i) begin
          st_d = S_FAIL; fcode_d = ST_REFUSED; fcode_en = 1'b1;
        end else if (grant_hit_i) begin
          st_d = S_XFER;
        end
      end
      S_XFER: begin
        if (expire_i) begin
          st_d = S_FAIL; fcode_d = ST_TIMEOUT; fcode_en = 1'b1;
        end else if (crc_err_i) begin
          st_d = S_FAIL; fcode_d = ST_CRC; fcode_en = 1'b1;
        end else if (snd_q ? (lcl_valid_i && lcl_last_i) : peer_end_i) begin
          st_d = S_CLOSE;
        end
      end
      S_CLOSE: begin
        if (expire_i) begin
          st_d = S_FAIL; fcode_d = ST_TIMEOUT; fcode_en = 1'b1;
        end else if (crc_err_i) begin
          st_d = S_FAIL; fcode_d = ST_CRC; fcode_en = 1'b1;
        end else if (!snd_q || unlink_i) begin
          st_d = S_IDLE; stat_d = ST_DONE; stat_en = 1'b1; done_d = 1'b1;
        end
      end
      S_FAIL: begin
        st_d = S_IDLE; stat_d = fcode_q; stat_en = 1'b1; done_d = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign snd_en = (st_q == S_IDLE) & req_i;
  assign snd_d  = req_sender_i | req_mcast_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fcode_q <= ST_DONE;
    else if (fcode_en) fcode_q <= fcode_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat_q <= ST_DONE;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snd_q <= 1'b0;
    else if (snd_en) snd_q <= snd_d;
  end

  assign load_o      = snd_en;
  assign clr_o       = (st_q == S_IDLE) & ~req_i;
  assign run_o       = (st_q == S_WAIT) | (st_q == S_XFER) | (st_q == S_CLOSE) | (st_q == S_ROUTE);
  assign inc_o       = (st_q == S_WAIT) & grant_i & ~expire_i & ~refuse_i;
  assign route_o     = (st_q == S_ROUTE);
  assign link_en_o   = (st_q == S_XFER);
  assign lcl_ready_o = (st_q == S_XFER) & snd_q;
  assign unlink_o    = (st_q == S_FAIL) | ((st_q == S_CLOSE) & ~snd_q);
  assign ot_o        = (st_q == S_FAIL) & (fcode_q == ST_TIMEOUT);
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = done_q;
  assign status_o    = stat_q;
endmodule

// File: rtl/cxn_setup_initiator.sv
module cxn_setup_initiator #(
  parameter int CNT_W = 4,
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_sender_i,
  input  logic             req_mcast_i,
  input  logic [CNT_W-1:0] req_grants_i,
  input  logic [TMR_W-1:0] tmo_i,
  output logic             route_o,
  input  logic             grant_i,
  input  logic             grant_refuse_i,
  input  logic             crc_err_i,
  input  logic             unlink_i,
  input  logic             peer_end_i,
  input  logic             lcl_valid_i,
  input  logic             lcl_last_i,
  output logic             lcl_ready_o,
  output logic             link_en_o,
  output logic             unlink_o,
  output logic             ot_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o
);
  logic load, clr, run, inc, expire, hit;

  cxn_watchdog #(.TMR_W(TMR_W)) i_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .clr_i     (clr),
    .run_i     (run),
    .value_i   (tmo_i),
    .expired_o (expire)
  );

  cxn_grant_ctr #(.CNT_W(CNT_W)) i_gctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .clr_i   (clr),
    .mcast_i (req_mcast_i),
    .need_i  (req_grants_i),
    .inc_i   (inc),
    .hit_o   (hit)
  );

  cxn_setup_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .req_sender_i (req_sender_i),
    .req_mcast_i  (req_mcast_i),
    .expire_i     (expire),
    .grant_i      (grant_i),
    .grant_hit_i  (hit),
    .refuse_i     (grant_refuse_i),
    .crc_err_i    (crc_err_i),
    .unlink_i     (unlink_i),
    .peer_end_i   (peer_end_i),
    .lcl_valid_i  (lcl_valid_i),
    .lcl_last_i   (lcl_last_i),
    .load_o       (load),
    .clr_o        (clr),
    .run_o        (run),
    .inc_o        (inc),
    .route_o      (route_o),
    .link_en_o    (link_en_o),
    .lcl_ready_o  (lcl_ready_o),
    .unlink_o     (unlink_o),
    .ot_o         (ot_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .status_o     (status_o)
  );
endmodule

// File: rtl/cxn_setup_chk.sv
module cxn_setup_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       grant_refuse_i,
  input logic       route_o,
  input logic       lcl_ready_o,
  input logic       link_en_o,
  input logic       unlink_o,
  input logic       ot_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] status_o
);
  AST_ROUTE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_o |=> !route_o); // R1
  AST_REQ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i) |=> (busy_o && route_o)); // R1
  AST_READY_NEEDS_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcl_ready_o |-> link_en_o); // R2
  AST_OT_UNLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_o |-> (unlink_o && !link_en_o)); // R5
  AST_OT_ENDS_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_o |=> (done_o && status_o == 2'd2)); // R5
  AST_EN_NOT_UNLINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_en_o |-> !unlink_o); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R11
  AST_STATUS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && $past(!done_o)) |-> $stable(status_o)); // R11
endmodule

bind cxn_setup_initiator cxn_setup_chk i_cxn_setup_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_i          (req_i),
  .grant_refuse_i (grant_refuse_i),
  .route_o        (route_o),
  .lcl_ready_o    (lcl_ready_o),
  .link_en_o      (link_en_o),
  .unlink_o       (unlink_o),
  .ot_o           (ot_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .status_o       (status_o)
);

// File: tb/test_cxn_setup_initiator.sv
`timescale 1ns/1ps
module test_cxn_setup_initiator;
  localparam int CNT_W = 4;
  localparam int TMR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, req_snd = 0, req_mc = 0;
  logic [CNT_W-1:0] req_p = '0;
  logic [TMR_W-1:0] tmo = '0;
  logic grant = 0, refuse = 0, crc = 0, unl_in = 0, peer_end = 0;
  logic lv = 0, ll = 0;
  logic route, rdy, len, unl_out, ot, busy, done;
  logic [1:0] status;

  int checks = 0;
  int fails  = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  cxn_setup_initiator #(.CNT_W(CNT_W), .TMR_W(TMR_W)) i_cxn_setup_initiator (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_sender_i(req_snd),
    .req_mcast_i(req_mc), .req_grants_i(req_p), .tmo_i(tmo), .route_o(route),
    .grant_i(grant), .grant_refuse_i(refuse), .crc_err_i(crc),
    .unlink_i(unl_in), .peer_end_i(peer_end), .lcl_valid_i(lv),
    .lcl_last_i(ll), .lcl_ready_o(rdy), .link_en_o(len), .unlink_o(unl_out),
    .ot_o(ot), .busy_o(busy), .done_o(done), .status_o(status)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: every done pulse pops one expected status
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected done", 1, 0);
      end else begin
        automatic logic [1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(status == e, t, status, e);
      end
    end
  end

  // driver: start an attempt and push the expected status
  task automatic start(input logic snd, input logic mc, input int p, input int t,
                       input logic [1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_snd = snd; req_mc = mc; req_p = CNT_W'(p); tmo = TMR_W'(t);
    req = 1;
    step(1);
    req = 0;
    chk(route == 1'b1, "R1 route strobe", route, 1);
    chk(busy == 1'b1, "R1 busy", busy, 1);
    step(1);
  endtask

  task automatic pulse_grant();
    grant = 1; step(1); grant = 0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // reset state
    chk(!busy && !route && !len && !rdy && !unl_out && !ot && !done,
        "R11 reset quiet", {busy, route, len, rdy}, 0);
    chk(status == 2'd0, "R11 reset status", status, 0);

    // unicast sender: backpressure, grant, beats, close
    lv = 1;
    start(1, 0, 0, 200, 2'd0, "R6 unicast sender done");
    chk(route == 0, "R1 route single", route, 0);
    chk(rdy == 0, "R2 backpressure before grant", rdy, 0);
    req = 1; step(1); req = 0; // stray request while busy
    chk(route == 0, "R1 request while busy ignored", route, 0);
    pulse_grant();
    chk(len == 1, "R3 unicast opens after one grant", len, 1);
    chk(rdy == 1, "R2 ready while open", rdy, 1);
    step(2);
    ll = 1; step(1); ll = 0; lv = 0;
    chk(len == 0, "R6 enable dropped after last", len, 0);
    chk(rdy == 0, "R2 ready low when closing", rdy, 0);
    step(2);
    chk(busy == 1 && !done, "R6 waits for far unlink", busy, 1);
    unl_in = 1; step(1); unl_in = 0;
    chk(done == 1, "R11 done pulse", done, 1);
    step(1);
    chk(done == 0 && busy == 0, "R11 done single", done, 0);

    // refuse
    start(1, 0, 0, 200, 2'd1, "R4 refused status");
    refuse = 1; step(1); refuse = 0;
    chk(len == 0 && unl_out == 1 && ot == 0, "R4 refuse unlocks, no link", len, 0);
    step(2);

    // timeout: count cycles from the request to ot
    begin
      automatic int n = 0;
      exp_q.push_back(2'd2); tag_q.push_back("R5 timeout status");
      req_snd = 1; req_mc = 0; tmo = TMR_W'(6);
      req = 1;
      while (!ot && n < 50) begin step(1); req = 0; n++; end
      chk(n == 8, "R5 expiry cycle", n, 8);
      chk(unl_out == 1 && len == 0, "R5 unlock on expiry", unl_out, 1);
    end
    step(2);

    // timeout wins over refuse and grant in the same cycle
    start(1, 0, 0, 1, 2'd2, "R5 expiry priority");
    refuse = 1; grant = 1; step(1); refuse = 0; grant = 0;
    chk(ot == 1, "R5 expiry beats refuse", ot, 1);
    step(2);

    // multicast P=3 aborted after two grants by refuse
    start(0, 1, 3, 200, 2'd1, "R10 aborted multicast");
    pulse_grant(); pulse_grant();
    chk(len == 0, "R3 multicast waits for P", len, 0);
    refuse = 1; step(1); refuse = 0;
    step(2);

    // fresh multicast P=3 with sender bit low: full count again, forced sender
    lv = 1;
    start(0, 1, 3, 300, 2'd0, "R8 multicast done");
    pulse_grant(); pulse_grant();
    chk(len == 0 && rdy == 0, "R10 grant count cleared", len, 0);
    pulse_grant();
    chk(len == 1, "R3 multicast opens at P", len, 1);
    chk(rdy == 1, "R8 multicast acts as sender", rdy, 1);
    ll = 1; step(1); ll = 0; lv = 0;
    unl_in = 1; step(1); unl_in = 0;
    step(2);

    // multicast with P=0 behaves as 1
    lv = 1;
    start(1, 1, 0, 300, 2'd0, "R3 P zero done");
    pulse_grant();
    chk(len == 1, "R3 P zero opens on first grant", len, 1);
    ll = 1; step(1); ll = 0; lv = 0;
    unl_in = 1; step(1); unl_in = 0;
    step(2);

    // receiver mode
    lv = 1;
    start(0, 0, 0, 300, 2'd0, "R7 receiver done");
    pulse_grant();
    chk(len == 1 && rdy == 0, "R7 open without ready", rdy, 0);
    step(2);
    chk(len == 1, "R7 stays open", len, 1);
    peer_end = 1; step(1); peer_end = 0; lv = 0;
    chk(unl_out == 1 && len == 0, "R7 unlink on peer end", unl_out, 1);
    step(1);
    chk(unl_out == 0, "R7 unlink single cycle", unl_out, 0);
    step(1);

    // CRC error during transfer
    start(1, 0, 0, 300, 2'd3, "R9 crc status");
    pulse_grant();
    crc = 1; step(1); crc = 0;
    chk(unl_out == 1 && ot == 0 && len == 0, "R9 crc unlock no ot", ot, 0);
    step(2);
    chk(status == 2'd3, "R11 status held", status, 3);

    chk(exp_q.size() == 0, "R11 all attempts completed", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule